// File: doc/BRIEF.md
# Packet Buffer Controller with Self-Advancing Data Ports

This block sits between a 16-bit register bus and an 8 KB packet memory inside a wireless interface. Software can reach the memory three ways. It can use a direct window that maps bus offsets onto memory halfwords. It can use a receive data port: each read of the port returns the halfword under a receive pointer, then moves that pointer forward and keeps it inside a circular region whose end and restart points software programs. It can use a transmit data port: each write of the port stores at a transmit pointer, then moves that pointer forward and jumps over a programmable hole in the buffer.

The bus carries one halfword access per cycle. Each access has an address, a read strobe and a write strobe. Read data is registered. It appears in the cycle after the read strobe and holds until the next read. A 32-bit access by the bus master is issued as two halfword accesses, the low half first. All addresses are full 32-bit values. Any address at or above a parameterised limit is dead. Below that limit, the offset used for decode is the address ANDed with 0x7FFE.

The register space below offset 0x2000 is visible twice: once at 0x0000–0x0FFF and again at 0x1000–0x1FFF. Only the lower copy triggers pointer movement. Plain register access works through either copy.

Top module: `pktbuf_ctrl`

## Requirements
- R1: After reset, the receive begin, receive end, receive pointer, transmit pointer, gap address and gap size registers all read 0.
- R2: Read data is valid in the cycle after the read strobe and holds until the next read.
- R3: Offsets 0x4000–0x5FFF (after the 0x7FFE mask) read and write the memory halfword at offset AND 0x1FFE. An address that differs only above bit 14 reaches the same halfword.
- R4: Offsets 0x2000–0x3FFF read 0xFFFF, and writes to them change nothing.
- R5: The plain read/write registers sit at these offsets: receive begin 0x050, receive end 0x052, receive pointer 0x054, transmit pointer 0x068, gap address 0x06A, gap size 0x06C. Each is also reachable at its offset plus 0x1000.
- R6: A read of the receive data port at 0x060 returns the memory halfword at (receive pointer AND 0x1FFE). The pointer then moves forward by 2.
- R7: If the moved receive pointer equals (receive end AND 0x1FFE), it is reloaded with (receive begin AND 0x1FFE). Otherwise it is stored ANDed with 0x1FFE, so moving past 0x1FFE gives 0.
- R8: A read of the receive data port through its upper copy at 0x1060 returns the last halfword fetched and leaves the receive pointer unchanged.
- R9: A write to the transmit data port at 0x070 stores the value at (transmit pointer AND 0x1FFE). The pointer then moves forward by 2.
- R10: If the moved transmit pointer equals (gap address AND 0x1FFE), it moves forward again by twice the gap size. The result is stored ANDed with 0x1FFE.
- R11: A write to the transmit data port through its upper copy at 0x1070 stores nothing and leaves the transmit pointer unchanged.
- R12: An address at or above 0x04810000 reads 0, and writes to it change nothing.
- R13: A 32-bit access made as two halfword accesses returns the halfword at addr in bits 15:0 and the halfword at addr+2 in bits 31:16. A 32-bit write stores its low half at addr and its high half at addr+2.
- R14: Offsets 0x6000–0x7FFE, unused register offsets and the transmit data port read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 32 | Full byte address of the halfword access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (takes priority over bus_rd) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after bus_rd |

## Verification
A wrong receive pointer shows up at the very next data-port read, which returns a halfword from the wrong location. It is also visible one cycle later when the pointer register is read back. A broken wrap or gap comparison stays hidden until a pointer reaches the end or gap mark. For that reason the directed cases place those marks a few halfwords from the start. A fault in the upper-copy gating moves a pointer silently, so every upper-copy access is followed by a read-back of the pointer.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

  // Decode classes for one bus access
  typedef enum logic [3:0] {
    K_ZERO, K_ONES, K_RAM,
    K_BEGIN, K_END, K_RPTR, K_RXDATA,
    K_WPTR, K_GAPA, K_GAPS, K_TXDATA
  } kind_e;

  localparam logic [15:0] OFF_MASK   = 16'h7FFE;
  localparam logic [15:0] RAM_LO     = 16'h4000;
  localparam logic [15:0] RAM_HI     = 16'h6000;
  localparam logic [15:0] ONES_LO    = 16'h2000;
  localparam logic [15:0] REG_TOP    = 16'h2000;
  localparam logic [15:0] MIRROR_AT  = 16'h1000;

  localparam logic [11:0] OFF_BEGIN  = 12'h050;
  localparam logic [11:0] OFF_END    = 12'h052;
  localparam logic [11:0] OFF_RPTR   = 12'h054;
  localparam logic [11:0] OFF_RXDATA = 12'h060;
  localparam logic [11:0] OFF_WPTR   = 12'h068;
  localparam logic [11:0] OFF_GAPA   = 12'h06A;
  localparam logic [11:0] OFF_GAPS   = 12'h06C;
  localparam logic [11:0] OFF_TXDATA = 12'h070;

endpackage

// File: rtl/pktbuf_decode.sv
module pktbuf_decode
  import pktbuf_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 32,
  parameter logic [ADDR_W-1:0]  HI_LIMIT = 'h0481_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output kind_e             kind,
  output logic              primary,
  output logic [15:0]       off
);

  always_comb begin
    off     = addr[15:0] & OFF_MASK;
    primary = (off < MIRROR_AT);
    kind    = K_ZERO;
    if (addr >= HI_LIMIT) begin
      kind = K_ZERO;
    end else if (off >= RAM_LO && off < RAM_HI) begin
      kind = K_RAM;
    end else if (off >= ONES_LO && off < RAM_LO) begin
      kind = K_ONES;
    end else if (off < REG_TOP) begin
      case (off[11:0])
        OFF_BEGIN:  kind = K_BEGIN;
        OFF_END:    kind = K_END;
        OFF_RPTR:   kind = K_RPTR;
        OFF_RXDATA: kind = K_RXDATA;
        OFF_WPTR:   kind = K_WPTR;
        OFF_GAPA:   kind = K_GAPA;
        OFF_GAPS:   kind = K_GAPS;
        OFF_TXDATA: kind = K_TXDATA;
        default:    kind = K_ZERO;
      endcase
    end
  end

endmodule

// File: rtl/pktbuf_step.sv
module pktbuf_step #(
  parameter int unsigned BAW      = 13,
  parameter bit          GAP_MODE = 1'b0
) (
  input  logic [15:0] cur,
  input  logic [15:0] mark,
  input  logic [15:0] alt,
  output logic [15:0] nxt
);

  localparam logic [15:0] PMASK = 16'((32'd1 << BAW) - 32'd2);

  logic [16:0] sum;
  logic        hit;

  assign sum = {1'b0, cur & PMASK} + 17'd2;
  assign hit = (sum == {1'b0, mark & PMASK});

  generate
    if (GAP_MODE) begin : g_gap
      logic [16:0] jumped;
      assign jumped = sum + {alt, 1'b0};
      assign nxt    = (hit ? jumped[15:0] : sum[15:0]) & PMASK;
    end else begin : g_wrap
      assign nxt = hit ? (alt & PMASK) : (sum[15:0] & PMASK);
    end
  endgenerate

endmodule

// File: rtl/pktbuf_ram.sv
module pktbuf_ram #(
  parameter int unsigned DW = 16,
  parameter int unsigned WAW = 12
) (
  input  logic           clk,
  input  logic           we,
  input  logic           re,
  input  logic [WAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  q
);

  localparam int unsigned DEPTH = 1 << WAW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end

endmodule

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl
  import pktbuf_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 32,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       RAM_BYTES = 8192,
  parameter logic [ADDR_W-1:0] HI_LIMIT  = 'h0481_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int unsigned BAW   = $clog2(RAM_BYTES);
  localparam int unsigned WAW   = BAW - 1;
  localparam logic [15:0] PMASK = 16'((32'd1 << BAW) - 32'd2);

  kind_e       kind;
  logic        primary;
  logic [15:0] off;

  pktbuf_decode #(.ADDR_W(ADDR_W), .HI_LIMIT(HI_LIMIT)) u_dec (
    .addr(bus_addr), .kind(kind), .primary(primary), .off(off)
  );

  logic [15:0] rx_begin, rx_end, rx_ptr, tx_ptr, gap_addr, gap_size;
  logic [15:0] rx_next, tx_next;
  logic [15:0] rx_last, rd_hold, rx_last_now;
  logic        rsel_ram, fetch_q;
  logic        do_rd, do_wr, rx_fire, tx_fire;
  logic        ram_we, ram_re;
  logic [WAW-1:0]    ram_addr;
  logic [DATA_W-1:0] ram_q;

  assign do_wr   = bus_wr;
  assign do_rd   = bus_rd & ~bus_wr;
  assign rx_fire = do_rd && kind == K_RXDATA && primary;
  assign tx_fire = do_wr && kind == K_TXDATA && primary;

  pktbuf_step #(.BAW(BAW), .GAP_MODE(1'b0)) u_rx_step (
    .cur(rx_ptr), .mark(rx_end), .alt(rx_begin), .nxt(rx_next)
  );

  pktbuf_step #(.BAW(BAW), .GAP_MODE(1'b1)) u_tx_step (
    .cur(tx_ptr), .mark(gap_addr), .alt(gap_size), .nxt(tx_next)
  );

  always_comb begin
    if (rx_fire)      ram_addr = rx_ptr[BAW-1:1];
    else if (tx_fire) ram_addr = tx_ptr[BAW-1:1];
    else              ram_addr = off[BAW-1:1];
  end

  assign ram_we = tx_fire | (do_wr && kind == K_RAM);
  assign ram_re = rx_fire | (do_rd && kind == K_RAM);

  pktbuf_ram #(.DW(DATA_W), .WAW(WAW)) u_ram (
    .clk(clk), .we(ram_we), .re(ram_re), .addr(ram_addr),
    .wdata(bus_wdata), .q(ram_q)
  );

  // Pointer and plain registers
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_begin <= '0;
      rx_end   <= '0;
      rx_ptr   <= '0;
      tx_ptr   <= '0;
      gap_addr <= '0;
      gap_size <= '0;
    end else begin
      if (do_wr) begin
        case (kind)
          K_BEGIN: rx_begin <= bus_wdata;
          K_END:   rx_end   <= bus_wdata;
          K_RPTR:  rx_ptr   <= bus_wdata;
          K_WPTR:  tx_ptr   <= bus_wdata;
          K_GAPA:  gap_addr <= bus_wdata;
          K_GAPS:  gap_size <= bus_wdata;
          default: ;
        endcase
      end
      if (rx_fire) rx_ptr <= rx_next;
      if (tx_fire) tx_ptr <= tx_next;
    end
  end

  // Read path: last fetched value tracks the memory output one cycle late
  assign rx_last_now = fetch_q ? ram_q : rx_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_ram <= 1'b0;
      rd_hold  <= '0;
      fetch_q  <= 1'b0;
      rx_last  <= '0;
    end else begin
      fetch_q <= rx_fire;
      if (fetch_q) rx_last <= ram_q;
      if (do_rd) begin
        rsel_ram <= ram_re;
        case (kind)
          K_ONES:   rd_hold <= '1;
          K_BEGIN:  rd_hold <= rx_begin;
          K_END:    rd_hold <= rx_end;
          K_RPTR:   rd_hold <= rx_ptr;
          K_RXDATA: rd_hold <= rx_last_now;
          K_WPTR:   rd_hold <= tx_ptr;
          K_GAPA:   rd_hold <= gap_addr;
          K_GAPS:   rd_hold <= gap_size;
          default:  rd_hold <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rsel_ram ? ram_q : rd_hold;

  // Assertions
  a_r8_mirror_keeps_rptr: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && kind == K_RXDATA && !primary) |=> $stable(rx_ptr));

  a_r11_mirror_keeps_wptr: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kind == K_TXDATA && !primary) |=> $stable(tx_ptr));

  a_r7_rptr_in_window: assert property (@(posedge clk) disable iff (rst)
    rx_fire |=> ((rx_ptr & ~PMASK) == 16'h0000));

  a_r10_wptr_in_window: assert property (@(posedge clk) disable iff (rst)
    tx_fire |=> ((tx_ptr & ~PMASK) == 16'h0000));

  a_r4_ones_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && kind == K_ONES) |=> (bus_rdata == 16'hFFFF));

  a_r12_high_read_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && bus_addr >= HI_LIMIT) |=> (bus_rdata == 16'h0000));

  a_r4_ones_write_no_ptr: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kind == K_ONES) |=> ($stable(rx_ptr) && $stable(tx_ptr)));

endmodule

// File: tb/pktbuf_ctrl_tb_top.sv
module pktbuf_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] bus_addr = '0;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  pktbuf_ctrl dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  localparam logic [31:0] BASE = 32'h0480_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr16(input logic [31:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd16(input logic [31:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr32(input logic [31:0] a, input logic [31:0] d);
    wr16(a, d[15:0]);
    wr16(a + 32'd2, d[31:16]);
  endtask

  task automatic rd32(input logic [31:0] a, output logic [31:0] d);
    logic [15:0] lo, hi;
    rd16(a, lo);
    rd16(a + 32'd2, hi);
    d = {hi, lo};
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd16(BASE + 32'h050, v); check("R1 begin", v, 0);
    rd16(BASE + 32'h052, v); check("R1 end", v, 0);
    rd16(BASE + 32'h054, v); check("R1 rptr", v, 0);
    rd16(BASE + 32'h068, v); check("R1 wptr", v, 0);
    rd16(BASE + 32'h06A, v); check("R1 gapa", v, 0);
    rd16(BASE + 32'h06C, v); check("R1 gaps", v, 0);
  endtask

  task automatic t_window;
    logic [15:0] v;
    wr16(BASE + 32'h4000, 16'h1234);
    wr16(BASE + 32'h5FFE, 16'hABCD);
    rd16(BASE + 32'h4000, v); check("R3 window lo", v, 16'h1234);
    rd16(BASE + 32'h5FFE, v); check("R3 window hi", v, 16'hABCD);
    rd16(BASE + 32'hC000, v); check("R3 alias above bit14", v, 16'h1234);
    repeat (3) @(negedge clk);
    check("R2 data held", bus_rdata, 16'h1234);
  endtask

  task automatic t_dead_regions;
    logic [15:0] v;
    wr16(BASE + 32'h2000, 16'h1111);
    rd16(BASE + 32'h2000, v); check("R4 ones read", v, 16'hFFFF);
    rd16(BASE + 32'h3FFE, v); check("R4 ones read top", v, 16'hFFFF);
    wr16(32'h0481_4000, 16'h5555);
    rd16(32'h0481_4000, v); check("R12 high read", v, 16'h0000);
    rd16(BASE + 32'h4000, v); check("R12 high write ignored", v, 16'h1234);
    rd16(BASE + 32'h6000, v); check("R14 upper region", v, 16'h0000);
    rd16(BASE + 32'h070, v); check("R14 tx port read", v, 16'h0000);
    rd16(BASE + 32'h040, v); check("R14 unused offset", v, 16'h0000);
  endtask

  task automatic t_regs;
    logic [15:0] v;
    wr16(BASE + 32'h06A, 16'hA5A4);
    rd16(BASE + 32'h106A, v); check("R5 mirror read gapa", v, 16'hA5A4);
    wr16(BASE + 32'h106C, 16'h0033);
    rd16(BASE + 32'h06C, v); check("R5 mirror write gaps", v, 16'h0033);
  endtask

  task automatic t_rx;
    logic [15:0] v;
    wr16(BASE + 32'h4100, 16'h0A00);
    wr16(BASE + 32'h4102, 16'h0A02);
    wr16(BASE + 32'h4104, 16'h0A04);
    wr16(BASE + 32'h050, 16'h0100);
    wr16(BASE + 32'h052, 16'h0106);
    wr16(BASE + 32'h054, 16'h0100);
    rd16(BASE + 32'h060, v); check("R6 first fetch", v, 16'h0A00);
    rd16(BASE + 32'h054, v); check("R6 ptr advance", v, 16'h0102);
    rd16(BASE + 32'h060, v); check("R6 second fetch", v, 16'h0A02);
    rd16(BASE + 32'h060, v); check("R6 third fetch", v, 16'h0A04);
    rd16(BASE + 32'h054, v); check("R7 wrap to begin", v, 16'h0100);
    rd16(BASE + 32'h060, v); check("R7 fetch after wrap", v, 16'h0A00);
    rd16(BASE + 32'h1060, v); check("R8 mirror returns last", v, 16'h0A00);
    rd16(BASE + 32'h054, v); check("R8 mirror no advance", v, 16'h0102);
    wr16(BASE + 32'h052, 16'h0000);
    wr16(BASE + 32'h054, 16'h1FFE);
    rd16(BASE + 32'h060, v); check("R6 fetch at top", v, 16'hABCD);
    rd16(BASE + 32'h054, v); check("R7 natural wrap", v, 16'h0000);
  endtask

  task automatic t_tx;
    logic [15:0] v;
    wr16(BASE + 32'h4204, 16'h7777);
    wr16(BASE + 32'h420E, 16'h6666);
    wr16(BASE + 32'h068, 16'h0200);
    wr16(BASE + 32'h06A, 16'h0204);
    wr16(BASE + 32'h06C, 16'h0004);
    wr16(BASE + 32'h070, 16'hC000);
    rd16(BASE + 32'h068, v); check("R9 ptr advance", v, 16'h0202);
    wr16(BASE + 32'h070, 16'hC002);
    rd16(BASE + 32'h068, v); check("R10 gap jump", v, 16'h020C);
    wr16(BASE + 32'h070, 16'hC00C);
    rd16(BASE + 32'h4200, v); check("R9 store 0", v, 16'hC000);
    rd16(BASE + 32'h4202, v); check("R9 store 1", v, 16'hC002);
    rd16(BASE + 32'h420C, v); check("R10 store after gap", v, 16'hC00C);
    rd16(BASE + 32'h4204, v); check("R10 gap untouched", v, 16'h7777);
    wr16(BASE + 32'h1070, 16'h9999);
    rd16(BASE + 32'h068, v); check("R11 mirror no advance", v, 16'h020E);
    rd16(BASE + 32'h420E, v); check("R11 mirror no store", v, 16'h6666);
  endtask

  task automatic t_wide;
    logic [15:0] v;
    logic [31:0] w;
    wr32(BASE + 32'h4300, 32'hDEAD_BEEF);
    rd16(BASE + 32'h4300, v); check("R13 low half first", v, 16'hBEEF);
    rd16(BASE + 32'h4302, v); check("R13 high half", v, 16'hDEAD);
    rd32(BASE + 32'h4300, w); check("R13 wide read", w, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_window();
    t_dead_regions();
    t_regs();
    t_rx();
    t_tx();
    t_wide();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule